// File: doc/BRIEF.md
# Endpoint Buffer Command Port

This block is the microcontroller side of a USB peripheral's endpoint buffer memory. The controller writes a command byte that picks one endpoint buffer and a transfer direction. After that it moves data with single strobes, one byte or one 16-bit word per strobe. An internal pointer steps through the selected buffer. Each buffer holds 64 payload bytes behind a 2-byte length header. Programmed access starts at the header, and DMA access starts just past it.

The USB serial side is reduced to simple side ports. One port writes whole OUT buffers, header included, and records the length each one carries. Another port reads back IN buffers byte by byte and clears an IN buffer's ready bit once it has been sent.

An IN buffer becomes ready when its last byte is written. It also becomes ready when an end-of-transfer pulse arrives during a DMA write session. In that case the block writes the number of bytes received into the header. A dedicated opcode returns the whole block to its reset state.

Top module: `epbuf_port`

## Requirements
- R1: Opcode 0x01 opens a write session on IN buffer 0 (control). Opcodes 0x02 to 0x0F open a write session on IN buffer code−1, which covers endpoints 1 to 14.
- R2: Opcode 0x10 opens a read session on OUT buffer 0. Opcodes 0x12 to 0x1F open a read session on OUT buffer code−0x11. Any other code except 0xF6 closes the session, and 0x11 is one of these codes. A data strobe after such a code then sets dir_err.
- R3: Opcode 0xF6 has the same effect as rst. From the next cycle, in_full is all zero, overrun, dir_err and dat_eop are low, no session is open, and every recorded OUT length is zero.
- R4: Each read or write command sets the pointer to offset 0 when cmd_dma is low and to offset 2 when it is high. Offsets 0 and 1 of a buffer hold the payload length, low byte first.
- R5: bus16 is sampled together with the command. In byte mode each strobe moves the byte at the pointer on bits 7:0, dat_out[15:8] reads 0, and the pointer advances by 1. In word mode the even offset travels on bits 7:0 and the odd offset on bits 15:8, and the pointer advances by 2.
- R6: An access made when the pointer has reached 66 is ignored. Memory is unchanged, dat_out and dat_eop are held, and the sticky flag overrun is set.
- R7: A dat_wr outside a write session, or a dat_rd outside a read session, is ignored and sets the sticky flag dir_err. Priority within a cycle runs from highest to lowest: cmd_valid, then an end-of-transfer commit, then dat_wr, then dat_rd.
- R8: in_full[e] rises in the cycle after the write that stores byte offset 65 of IN buffer e.
- R9: An eot during a DMA write session sets in_full for that buffer. It also writes the count of bytes stored past the header into offsets 0 and 1, low byte first, and closes the session. An eot at any other time has no effect.
- R10: dat_eop is updated with every accepted read. It is high only in a DMA session, and only when the access covers offset L+1, where L is the length the serial side wrote to offsets 0 and 1 of that OUT buffer.
- R11: sie_in_clr clears in_full[sie_in_ep] from the next cycle. If a set of the same bit happens in that cycle, the set wins.
- R12: dat_out is valid one cycle after an accepted dat_rd and is held until the next accepted read. sie_in_data gives the IN byte at sie_in_addr one cycle after sie_in_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command opcode |
| cmd_dma | input | 1 | Command opens a DMA session (header skipped) |
| bus16 | input | 1 | Command opens a 16-bit session |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe |
| dat_in | input | 16 | Write data |
| dat_out | output | 16 | Read data |
| dat_eop | output | 1 | Last valid OUT data reached (DMA) |
| eot | input | 1 | End of transfer, commits a partial DMA IN buffer |
| in_full | output | NUM_EP | Per IN buffer ready-to-send bits |
| overrun | output | 1 | Sticky access-past-end flag |
| dir_err | output | 1 | Sticky direction error flag |
| sie_out_wr | input | 1 | Serial side OUT buffer byte write |
| sie_out_ep | input | EPW | Serial side OUT buffer index |
| sie_out_addr | input | PW | Serial side OUT byte offset |
| sie_out_data | input | 8 | Serial side OUT byte |
| sie_in_rd | input | 1 | Serial side IN byte read strobe |
| sie_in_ep | input | EPW | Serial side IN buffer index (read and clear) |
| sie_in_addr | input | PW | Serial side IN byte offset |
| sie_in_data | output | 8 | Serial side IN byte |
| sie_in_clr | input | 1 | Clear ready bit of IN buffer sie_in_ep |

## Verification
Several properties are checked on every cycle. The overrun and direction-error flags must stay set until a reset. The reset opcode must clear every ready bit and flag. dat_eop and dat_out may change only after a read strobe. A ready bit may rise only after a write or an end-of-transfer, and a drain must clear it. Other behaviour is shown only by the bench's scenarios against its byte-level model of both memories: how opcodes map to buffers, where the pointer starts in programmed and DMA sessions, byte-lane order in word mode, the header count written on an early commit, and the exact read that raises dat_eop.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  typedef enum logic [1:0] {CMD_NONE, CMD_WRITE, CMD_READ, CMD_RESET} cmd_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} sess_e;
  localparam logic [7:0] OPC_RESET   = 8'hF6;
  localparam logic [7:0] OPC_WR_BASE = 8'h01;
  localparam logic [7:0] OPC_RD_BASE = 8'h10;
endpackage

// File: rtl/epbuf_cmd_dec.sv
module epbuf_cmd_dec
  import epbuf_pkg::*;
#(
  parameter int NUM_EP = 15,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic [7:0]     code,
  output cmd_kind_e      kind,
  output logic [EPW-1:0] ep
);
  always_comb begin
    kind = CMD_NONE;
    ep   = '0;
    if (code == OPC_RESET) begin
      kind = CMD_RESET;
    end else if (code >= OPC_WR_BASE && code <= OPC_WR_BASE + 8'(NUM_EP - 1)) begin
      kind = CMD_WRITE;
      ep   = EPW'(code - OPC_WR_BASE);
    end else if (code == OPC_RD_BASE) begin
      kind = CMD_READ;
    end else if (code >= OPC_RD_BASE + 8'd2 && code <= OPC_RD_BASE + 8'(NUM_EP)) begin
      kind = CMD_READ;
      ep   = EPW'(code - OPC_RD_BASE - 8'd1);
    end
  end
endmodule

// File: rtl/epbuf_ram.sv
module epbuf_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [7:0] lane_lo [DEPTH];
  logic [7:0] lane_hi [DEPTH];

  always_ff @(posedge clk) begin
    if (we_lo) lane_lo[waddr] <= wdata[7:0];
    if (we_hi) lane_hi[waddr] <= wdata[15:8];
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= {lane_hi[raddr], lane_lo[raddr]};
  end
endmodule

// File: rtl/epbuf_port.sv
module epbuf_port
  import epbuf_pkg::*;
#(
  parameter int NUM_EP  = 15,
  parameter int PAYLOAD = 64,
  localparam int BUF_BYTES = PAYLOAD + 2,
  localparam int EPW = $clog2(NUM_EP),
  localparam int PW  = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              cmd_dma,
  input  logic              bus16,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [15:0]       dat_in,
  output logic [15:0]       dat_out,
  output logic              dat_eop,
  input  logic              eot,
  output logic [NUM_EP-1:0] in_full,
  output logic              overrun,
  output logic              dir_err,
  input  logic              sie_out_wr,
  input  logic [EPW-1:0]    sie_out_ep,
  input  logic [PW-1:0]     sie_out_addr,
  input  logic [7:0]        sie_out_data,
  input  logic              sie_in_rd,
  input  logic [EPW-1:0]    sie_in_ep,
  input  logic [PW-1:0]     sie_in_addr,
  output logic [7:0]        sie_in_data,
  input  logic              sie_in_clr
);
  localparam int WPB = (BUF_BYTES + 1) / 2;
  localparam int WAW = $clog2(WPB);
  localparam int AW  = EPW + WAW;
  localparam logic [PW-1:0] LIMIT = PW'(BUF_BYTES);

  cmd_kind_e      dec_kind;
  logic [EPW-1:0] dec_ep;
  epbuf_cmd_dec #(.NUM_EP(NUM_EP)) u_dec (.code(cmd_code), .kind(dec_kind), .ep(dec_ep));

  sess_e          sess;
  logic [EPW-1:0] sess_ep;
  logic           sess_dma, sess_w16;
  logic [PW-1:0]  ptr;
  logic [15:0]    out_len [NUM_EP];

  // event decode, priority: command > commit > write > read
  logic          is_rst_cmd, commit, wr_ev, rd_ev, wr_go, rd_go, dir_hit, ovr_hit, at_limit;
  logic [PW-1:0] step, ptr_nxt;
  logic [16:0]   last_off, p_lo, p_hi;
  logic          eop_nxt;

  always_comb begin
    is_rst_cmd = cmd_valid && dec_kind == CMD_RESET;
    commit     = !cmd_valid && eot && sess == S_WR && sess_dma;
    wr_ev      = !cmd_valid && !commit && dat_wr;
    rd_ev      = !cmd_valid && !commit && !dat_wr && dat_rd;
    at_limit   = ptr >= LIMIT;
    wr_go      = wr_ev && sess == S_WR && !at_limit;
    rd_go      = rd_ev && sess == S_RD && !at_limit;
    dir_hit    = (wr_ev && sess != S_WR) || (rd_ev && sess != S_RD);
    ovr_hit    = (wr_ev && sess == S_WR && at_limit) || (rd_ev && sess == S_RD && at_limit);
    step       = sess_w16 ? PW'(2) : PW'(1);
    ptr_nxt    = ptr + step;
    last_off   = {1'b0, out_len[sess_ep]} + 17'd1;
    p_lo       = 17'(ptr);
    p_hi       = 17'(ptr) + 17'(step) - 17'd1;
    eop_nxt    = sess_dma && p_lo <= last_off && last_off <= p_hi;
  end

  // IN buffer memory: host writes, serial side reads
  logic          in_we_lo, in_we_hi;
  logic [AW-1:0] in_waddr, in_raddr;
  logic [15:0]   in_wdata, in_rdata;
  always_comb begin
    in_we_lo = commit || (wr_go && (sess_w16 || !ptr[0]));
    in_we_hi = commit || (wr_go && (sess_w16 || ptr[0]));
    in_waddr = {sess_ep, commit ? WAW'(0) : WAW'(ptr >> 1)};
    in_wdata = commit ? 16'(ptr) - 16'd2 : (sess_w16 ? dat_in : {dat_in[7:0], dat_in[7:0]});
    in_raddr = {sie_in_ep, WAW'(sie_in_addr >> 1)};
  end
  epbuf_ram #(.AW(AW)) u_in_ram (
    .clk(clk), .we_lo(in_we_lo), .we_hi(in_we_hi), .waddr(in_waddr), .wdata(in_wdata),
    .re(sie_in_rd), .raddr(in_raddr), .rdata(in_rdata));

  // OUT buffer memory: serial side writes, host reads
  logic [15:0] out_rdata;
  epbuf_ram #(.AW(AW)) u_out_ram (
    .clk(clk),
    .we_lo(sie_out_wr && !sie_out_addr[0]), .we_hi(sie_out_wr && sie_out_addr[0]),
    .waddr({sie_out_ep, WAW'(sie_out_addr >> 1)}), .wdata({sie_out_data, sie_out_data}),
    .re(rd_go), .raddr({sess_ep, WAW'(ptr >> 1)}), .rdata(out_rdata));

  // lane selection for the registered read data
  logic rd_lane, rd_w16, sie_lane;
  always_ff @(posedge clk) begin
    if (rd_go) begin
      rd_lane <= ptr[0];
      rd_w16  <= sess_w16;
    end
    if (sie_in_rd) sie_lane <= sie_in_addr[0];
  end
  assign dat_out     = rd_w16 ? out_rdata : {8'h00, rd_lane ? out_rdata[15:8] : out_rdata[7:0]};
  assign sie_in_data = sie_lane ? in_rdata[15:8] : in_rdata[7:0];

  // session, pointer, flags
  always_ff @(posedge clk) begin
    if (rst || is_rst_cmd) begin
      sess     <= S_IDLE;
      sess_ep  <= '0;
      sess_dma <= 1'b0;
      sess_w16 <= 1'b0;
      ptr      <= '0;
      in_full  <= '0;
      overrun  <= 1'b0;
      dir_err  <= 1'b0;
      dat_eop  <= 1'b0;
      for (int i = 0; i < NUM_EP; i++) out_len[i] <= '0;
    end else begin
      if (sie_out_wr && sie_out_addr < PW'(2) && {1'b0, sie_out_ep} < (EPW+1)'(NUM_EP)) begin
        if (sie_out_addr[0]) out_len[sie_out_ep][15:8] <= sie_out_data;
        else                 out_len[sie_out_ep][7:0]  <= sie_out_data;
      end
      if (sie_in_clr && {1'b0, sie_in_ep} < (EPW+1)'(NUM_EP)) in_full[sie_in_ep] <= 1'b0;
      if (cmd_valid) begin
        case (dec_kind)
          CMD_WRITE, CMD_READ: begin
            sess     <= (dec_kind == CMD_WRITE) ? S_WR : S_RD;
            sess_ep  <= dec_ep;
            sess_dma <= cmd_dma;
            sess_w16 <= bus16;
            ptr      <= cmd_dma ? PW'(2) : PW'(0);
          end
          default: sess <= S_IDLE;
        endcase
      end else if (commit) begin
        in_full[sess_ep] <= 1'b1;
        sess             <= S_IDLE;
      end else begin
        if (dir_hit) dir_err <= 1'b1;
        if (ovr_hit) overrun <= 1'b1;
        if (wr_go) begin
          ptr <= ptr_nxt;
          if (ptr_nxt == LIMIT) in_full[sess_ep] <= 1'b1;
        end
        if (rd_go) begin
          ptr     <= ptr_nxt;
          dat_eop <= eop_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/epbuf_port_chk.sv
module epbuf_port_chk #(
  parameter int NUM_EP = 15,
  parameter int EPW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic              dat_wr,
  input logic              dat_rd,
  input logic [15:0]       dat_out,
  input logic              dat_eop,
  input logic              eot,
  input logic [NUM_EP-1:0] in_full,
  input logic              overrun,
  input logic              dir_err,
  input logic [EPW-1:0]    sie_in_ep,
  input logic              sie_in_clr
);
  logic rst_cmd;
  assign rst_cmd = cmd_valid && cmd_code == 8'hF6;

  AST_RST_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rst_cmd |=> (in_full == '0 && !overrun && !dir_err && !dat_eop)); // R3
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun && !rst_cmd |=> overrun); // R6
  AST_DIR_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    dir_err && !rst_cmd |=> dir_err); // R7
  AST_EOP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_eop) |-> $past(dat_rd)); // R10
  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !dat_rd |=> $stable(dat_out)); // R12
  AST_FULL_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (in_full & ~$past(in_full)) != '0 |-> $past(dat_wr || eot)); // R8
  AST_FULL_DRAINED: assert property (@(posedge clk) disable iff (rst)
    sie_in_clr && !cmd_valid && !dat_wr && !eot && ({1'b0, sie_in_ep} < (EPW+1)'(NUM_EP))
    |=> !in_full[$past(sie_in_ep)]); // R11
endmodule

bind epbuf_port epbuf_port_chk #(.NUM_EP(NUM_EP), .EPW(EPW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .dat_wr(dat_wr),
  .dat_rd(dat_rd), .dat_out(dat_out), .dat_eop(dat_eop), .eot(eot), .in_full(in_full),
  .overrun(overrun), .dir_err(dir_err), .sie_in_ep(sie_in_ep), .sie_in_clr(sie_in_clr));

// File: tb/epbuf_port_tb.sv
module epbuf_port_tb;
  localparam int NEP = 15;
  localparam int BB  = 66;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_dma = 0, bus16 = 0;
  logic [7:0] cmd_code = 0;
  logic dat_wr = 0, dat_rd = 0, eot = 0;
  logic [15:0] dat_in = 0;
  wire  [15:0] dat_out;
  wire  dat_eop, overrun, dir_err;
  wire  [NEP-1:0] in_full;
  logic sie_out_wr = 0, sie_in_rd = 0, sie_in_clr = 0;
  logic [3:0] sie_out_ep = 0, sie_in_ep = 0;
  logic [6:0] sie_out_addr = 0, sie_in_addr = 0;
  logic [7:0] sie_out_data = 0;
  wire  [7:0] sie_in_data;

  epbuf_port u_dut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  // bench model
  logic [7:0] in_img [NEP*BB];
  bit         in_vld [NEP*BB];
  logic [7:0] out_img [NEP*BB];
  int m_olen [NEP];
  int m_sess = 0, m_ep = 0, m_ptr = 0;
  bit m_dma = 0, m_w16 = 0, m_ovr = 0, m_derr = 0, m_eop = 0;
  logic [NEP-1:0] m_full = '0;
  logic [15:0] m_dout = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(string tag);
    chk({tag, " in_full"}, int'(in_full), int'(m_full));
    chk({tag, " overrun"}, overrun, m_ovr);
    chk({tag, " dir_err"}, dir_err, m_derr);
  endtask

  task automatic cmd(input logic [7:0] code, input bit dma, input bit w16);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; cmd_dma = dma; bus16 = w16;
    @(negedge clk);
    cmd_valid = 0;
    if (code == 8'hF6) begin
      m_full = '0; m_ovr = 0; m_derr = 0; m_sess = 0; m_eop = 0;
      for (int i = 0; i < NEP; i++) m_olen[i] = 0;
    end else begin
      m_ptr = dma ? 2 : 0; m_dma = dma; m_w16 = w16;
      if (code >= 8'h01 && code <= 8'h0F) begin m_sess = 1; m_ep = code - 1; end
      else if (code == 8'h10) begin m_sess = 2; m_ep = 0; end
      else if (code >= 8'h12 && code <= 8'h1F) begin m_sess = 2; m_ep = code - 8'h11; end
      else m_sess = 0;
    end
  endtask

  task automatic host_wr(input logic [15:0] d);
    @(negedge clk);
    dat_wr = 1; dat_in = d;
    @(negedge clk);
    dat_wr = 0;
    if (m_sess != 1) m_derr = 1;
    else if (m_ptr >= BB) m_ovr = 1;
    else begin
      in_img[m_ep*BB+m_ptr] = d[7:0]; in_vld[m_ep*BB+m_ptr] = 1;
      if (m_w16) begin in_img[m_ep*BB+m_ptr+1] = d[15:8]; in_vld[m_ep*BB+m_ptr+1] = 1; end
      m_ptr += m_w16 ? 2 : 1;
      if (m_ptr == BB) m_full[m_ep] = 1;
    end
  endtask

  task automatic host_rd(string tag);
    int step, last;
    @(negedge clk);
    dat_rd = 1;
    @(negedge clk);
    dat_rd = 0;
    step = m_w16 ? 2 : 1;
    if (m_sess != 2) m_derr = 1;
    else if (m_ptr >= BB) m_ovr = 1;
    else begin
      m_dout = m_w16 ? {out_img[m_ep*BB+m_ptr+1], out_img[m_ep*BB+m_ptr]}
                     : {8'h00, out_img[m_ep*BB+m_ptr]};
      last  = m_olen[m_ep] + 1;
      m_eop = m_dma && m_ptr <= last && last <= m_ptr + step - 1;
      m_ptr += step;
    end
    chk({tag, " dat_out"}, dat_out, m_dout);
    chk({tag, " dat_eop"}, dat_eop, m_eop);
  endtask

  task automatic pulse_eot();
    @(negedge clk); eot = 1;
    @(negedge clk); eot = 0;
    if (m_sess == 1 && m_dma) begin
      in_img[m_ep*BB]   = 8'(m_ptr - 2);
      in_img[m_ep*BB+1] = 8'((m_ptr - 2) >> 8);
      in_vld[m_ep*BB] = 1; in_vld[m_ep*BB+1] = 1;
      m_full[m_ep] = 1; m_sess = 0;
    end
  endtask

  task automatic sie_fill(input int ep, input int len);
    for (int o = 0; o < BB; o++) begin
      logic [7:0] b;
      b = (o == 0) ? 8'(len) : (o == 1) ? 8'(len >> 8) : 8'($urandom);
      @(negedge clk);
      sie_out_wr = 1; sie_out_ep = 4'(ep); sie_out_addr = 7'(o); sie_out_data = b;
      out_img[ep*BB+o] = b;
    end
    @(negedge clk); sie_out_wr = 0;
    m_olen[ep] = len;
  endtask

  task automatic sie_check(input int ep, string tag);
    for (int o = 0; o < BB; o++) begin
      if (in_vld[ep*BB+o]) begin
        @(negedge clk); sie_in_rd = 1; sie_in_ep = 4'(ep); sie_in_addr = 7'(o);
        @(negedge clk); sie_in_rd = 0;
        chk(tag, sie_in_data, in_img[ep*BB+o]);
      end
    end
  endtask

  task automatic sie_clear(input int ep);
    @(negedge clk); sie_in_clr = 1; sie_in_ep = 4'(ep);
    @(negedge clk); sie_in_clr = 0;
    m_full[ep] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1-all: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1181));
    for (int i = 0; i < NEP*BB; i++) in_vld[i] = 0;
    for (int i = 0; i < NEP; i++) m_olen[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_flags("R3 reset");
    chk("R3 reset eop", dat_eop, 0);
    for (int e = 0; e < NEP; e++) sie_fill(e, 64);

    // R7: read with no session, then R3: reset opcode clears
    host_rd("R7 no session");
    chk_flags("R7 no session");
    cmd(8'hF6, 0, 0);
    chk_flags("R3 opcode");
    // R2: 0x11 opens nothing
    cmd(8'h11, 0, 0);
    host_rd("R2 code 11");
    chk_flags("R2 code 11");
    cmd(8'hF6, 0, 0);

    // R2 R4 R5 R10: programmed byte read of OUT 3 (code 0x14)
    sie_fill(3, 5);
    cmd(8'h14, 0, 0);
    for (int k = 0; k < 8; k++) host_rd("R5 R10 byte prog");
    // R4 R10 R6: DMA word read of control OUT, full length, then one past the end
    sie_fill(0, 64);
    cmd(8'h10, 1, 1);
    for (int k = 0; k < 33; k++) host_rd("R4 R10 R6 dma word");
    chk_flags("R6 read overrun");
    cmd(8'hF6, 0, 0);

    // R1 R5 R8 R6: programmed word write of IN 14 (code 0x0F)
    cmd(8'h0F, 0, 1);
    for (int k = 0; k < 32; k++) host_wr(16'($urandom));
    chk("R8 not yet full", in_full[14], 0);
    host_wr(16'($urandom));
    chk_flags("R8 full");
    host_wr(16'hBEEF);
    chk_flags("R6 write overrun");
    sie_check(14, "R1 R5 R12 in data");
    sie_clear(14);
    chk_flags("R11 drain");
    cmd(8'hF6, 0, 0);

    // R9: DMA byte write of IN 1 (code 0x02), early commit
    cmd(8'h02, 1, 0);
    for (int k = 0; k < 5; k++) host_wr(16'($urandom));
    pulse_eot();
    chk_flags("R9 commit");
    sie_check(1, "R9 header");
    pulse_eot();
    chk_flags("R9 stray eot");
    // R7: read in write session leaves memory alone
    cmd(8'h03, 0, 0);
    host_wr(16'h005A);
    host_rd("R7 wrong dir");
    chk_flags("R7 wrong dir");
    sie_check(2, "R7 memory");
    cmd(8'hF6, 0, 0);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int ep, n;
      bit dma, w16;
      ep = $urandom % NEP; dma = $urandom % 2; w16 = $urandom % 2;
      if ($urandom % 2) begin
        sie_fill(ep, $urandom % 65);
        cmd(ep == 0 ? 8'h10 : 8'(8'h11 + ep), dma, w16);
        n = 1 + $urandom % 70;
        for (int k = 0; k < n; k++) host_rd("R5 R10 R12 rand read");
      end else begin
        cmd(8'(8'h01 + ep), dma, w16);
        n = 1 + $urandom % 70;
        for (int k = 0; k < n; k++) host_wr(16'($urandom));
        if (dma && ($urandom % 2)) pulse_eot();
        chk_flags("R6 R8 R9 rand write");
        sie_check(ep, "R1 R5 rand in data");
        if ($urandom % 2) begin sie_clear(ep); chk_flags("R11 rand drain"); end
      end
      if ($urandom % 4 == 0) begin cmd(8'hF6, 0, 0); chk_flags("R3 rand reset"); end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule